// File: doc/BRIEF.md
# Descriptor Chain Transmit Engine

This block is the transmit half of one DMA channel. Software builds a chain of descriptors in memory, each three 32-bit words long, and pulses a start input with the address of the first one. The engine reads each descriptor and validates it. It then reads the referenced buffer one word at a time and sends the valid bytes, one per handshake, on a valid/ready byte stream toward a peripheral. After the last byte it writes the control word back with the ownership bit cleared, then follows the next pointer.

A descriptor that fails validation locks the engine. It raises a one-cycle error interrupt and stops until a reset. When the descriptor flagged as the chain's end has been sent, the engine pulses a completion interrupt and records that descriptor's address. A restart pulse lets software append descriptors. If the chain has already ended, the engine re-reads the third word of the last descriptor and carries on from there. If it is still running, the request is held and applied when the current descriptor completes.

Top module: `dscr_chain_tx`

## Requirements
- R1: After a start pulse with address A, the engine reads the words at A, A+4 and A+8. These are the control word, the buffer pointer and the next pointer. The control word has the owner flag at bit 31, the end-of-chain flag at bit 30 and the byte count at bits 23:12. A descriptor without the end flag is followed by the one at its next pointer.
- R2: For each descriptor the stream carries exactly the byte count, taken from consecutive addresses starting at the buffer pointer. Any byte alignment is allowed. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared.
- R3: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged in the next cycle.
- R4: With check_owner_i high, a control word whose bit 31 is 0 raises dscr_err_irq_o for one cycle, and no byte of that descriptor is sent. With check_owner_i low, the owner flag is not checked.
- R5: A buffer pointer below 0x3FC80000 or above 0x3FCDFFFF raises the error whatever check_owner_i is. The two boundary addresses themselves are accepted.
- R6: After an error the engine issues no memory request and no stream byte, and it ignores start and restart. Only rst_n followed by a start brings it back to work.
- R7: Once a descriptor's bytes are all sent, its control word is written back to its own address with bit 31 cleared and all other bits unchanged. While loop_test_i is high, no write is issued.
- R8: When the descriptor with the end flag is complete, eoc_irq_o is high for exactly one cycle and last_dscr_addr_o holds that descriptor's address. last_dscr_addr_o changes at no other time.
- R9: A restart pulse after the chain has ended makes the engine re-read word 2 of the last descriptor and process the chain found at that address.
- R10: A restart pulse while the engine is running is held until the current descriptor is complete. The engine then re-reads that descriptor's word 2 and continues from there, with no end-of-chain pulse for that descriptor.
- R11: A restart before any start, and a start while a chain is running, have no effect.
- R12: After reset, mem_req_o, tx_valid_o and both interrupts are low, and last_dscr_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the channel |
| start_i | input | 1 | One-cycle pulse: begin a chain at first_addr_i |
| restart_i | input | 1 | One-cycle pulse: continue from the last descriptor's next pointer |
| first_addr_i | input | 32 | Address of the first descriptor |
| check_owner_i | input | 1 | Enables the owner-flag check |
| loop_test_i | input | 1 | Suppresses control-word write-back |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle; read data is valid with it |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Peripheral accepts the byte |
| eoc_irq_o | output | 1 | One-cycle pulse: end-of-chain descriptor transmitted |
| dscr_err_irq_o | output | 1 | One-cycle pulse: descriptor rejected, engine locked |
| last_dscr_addr_o | output | 32 | Address of the last completed end-of-chain descriptor |

## Verification
A wrong fetch state shows up on the stream within a descriptor. Bytes go missing, are repeated, or come from the wrong offset. A skipped or doubled write-back leaves a stale owner bit in memory, visible as soon as the chain ends. A mishandled restart shows up as a missing or extra completion pulse, or as the wrong recorded address, at the end of the resumed chain. A lock that leaks shows up as a memory request or a byte within a few cycles of a start issued after an error.

// File: rtl/dscr_pkg.sv
// Shared definitions for the descriptor chain transmit engine.
// Assumes 32-bit descriptor words and a byte-addressed memory.
package dscr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OWN_BIT  = 31;
    localparam int unsigned EOC_BIT  = 30;
    localparam int unsigned CNT_LSB  = 12;
    localparam int unsigned CNT_W    = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W0,
        ST_W1,
        ST_W2,
        ST_CHK,
        ST_XFER,
        ST_WB,
        ST_LINK,
        ST_END,
        ST_STUCK
    } eng_state_e;

    // Extracts the valid byte count from a control word.
    function automatic logic [CNT_W-1:0] ctrl_count(input logic [WORD_W-1:0] c);
        return c[CNT_LSB +: CNT_W];
    endfunction
endpackage

// File: rtl/dscr_check.sv
// Descriptor validator. Purely combinational.
// Flags an owner fault (only while checking is enabled) and a buffer
// pointer outside the inclusive window [WIN_LO, WIN_HI].
module dscr_check #(
    parameter int unsigned AW = 32,
    parameter logic [AW-1:0] WIN_LO = 32'h3FC8_0000,
    parameter logic [AW-1:0] WIN_HI = 32'h3FCD_FFFF
) (
    input  logic          owner_i,
    input  logic          chk_owner_i,
    input  logic [AW-1:0] buf_i,
    output logic          owner_bad_o,
    output logic          range_bad_o
);
    // Fault decode for the owner flag and the address window.
    always_comb begin
        owner_bad_o = chk_owner_i && !owner_i;
        range_bad_o = (buf_i < WIN_LO) || (buf_i > WIN_HI);
    end
endmodule

// File: rtl/tx_byte_pump.sv
// Byte pump. Once loaded with a start address and a byte count, it fetches
// words through a request/acknowledge read port and presents their bytes
// one at a time on a valid/ready stream, in little-endian order.
// Assumes the read data arrives in the same cycle as the acknowledge.
// busy_o stays high until the last byte is accepted.
module tx_byte_pump #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [LW-1:0] len_i,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [7:0]    tx_data_o,
    output logic          tx_valid_o,
    input  logic          tx_ready_i
);
    localparam int unsigned NB   = DW / 8;
    localparam int unsigned OFSW = $clog2(NB);
    localparam logic [OFSW-1:0] LAST_OFS = OFSW'(NB - 1);

    logic [AW-1:0] ptr_q;
    logic [LW-1:0] left_q;
    logic [DW-1:0] word_q;
    logic          full_q;

    // Derived handshake and output views of the pump state.
    always_comb begin
        busy_o     = (left_q != '0);
        rd_req_o   = busy_o && !full_q;
        rd_addr_o  = {ptr_q[AW-1:OFSW], {OFSW{1'b0}}};
        tx_valid_o = full_q;
        tx_data_o  = word_q[{ptr_q[OFSW-1:0], 3'b000} +: 8];
    end

    // Load, word capture and per-byte advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
            word_q <= '0;
            full_q <= 1'b0;
        end else if (load_i) begin
            ptr_q  <= addr_i;
            left_q <= len_i;
            full_q <= 1'b0;
        end else if (rd_req_o && rd_ack_i) begin
            word_q <= rd_data_i;
            full_q <= 1'b1;
        end else if (full_q && tx_ready_i) begin
            ptr_q  <= ptr_q + AW'(1);
            left_q <= left_q - LW'(1);
            if (ptr_q[OFSW-1:0] == LAST_OFS || left_q == LW'(1)) begin
                full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dscr_chain_tx.sv
// Descriptor chain transmit engine, the top level.
// It walks a chain of three-word descriptors, validates each one, streams
// its buffer through tx_byte_pump, writes the control word back and
// follows the next pointer. A rejected descriptor locks the engine until
// rst_n. Restart requests re-read the next pointer of the current or last
// descriptor. One memory port is shared: the pump owns it during ST_XFER.
module dscr_chain_tx
    import dscr_pkg::*;
#(
    parameter logic [31:0] WIN_LO = 32'h3FC8_0000,
    parameter logic [31:0] WIN_HI = 32'h3FCD_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        restart_i,
    input  logic [31:0] first_addr_i,
    input  logic        check_owner_i,
    input  logic        loop_test_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i,
    output logic [7:0]  tx_data_o,
    output logic        tx_valid_o,
    input  logic        tx_ready_i,
    output logic        eoc_irq_o,
    output logic        dscr_err_irq_o,
    output logic [31:0] last_dscr_addr_o
);
    localparam int unsigned AW      = WORD_W;
    localparam int unsigned WBYTES  = WORD_W / 8;
    localparam logic [AW-1:0] OFS_BUF  = AW'(WBYTES);
    localparam logic [AW-1:0] OFS_NEXT = AW'(2 * WBYTES);
    localparam logic [WORD_W-1:0] OWN_CLR = ~(WORD_W'(1) << OWN_BIT);

    eng_state_e    state_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] next_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [AW-1:0] last_q;
    logic          rs_pend_q;
    logic          eoc_q;
    logic          err_q;

    logic          owner_bad;
    logic          range_bad;
    logic          dscr_bad;
    logic          pump_load;
    logic          pump_busy;
    logic          pump_req;
    logic [AW-1:0] pump_addr;
    logic          pump_ack;
    logic          running;
    logic          wb_done;
    logic          restart_any;

    dscr_check #(
        .AW     (AW),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_check (
        .owner_i     (ctrl_q[OWN_BIT]),
        .chk_owner_i (check_owner_i),
        .buf_i       (buf_q),
        .owner_bad_o (owner_bad),
        .range_bad_o (range_bad)
    );

    tx_byte_pump #(
        .AW (AW),
        .DW (WORD_W),
        .LW (CNT_W)
    ) u_pump (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (pump_load),
        .addr_i     (buf_q),
        .len_i      (ctrl_count(ctrl_q)),
        .busy_o     (pump_busy),
        .rd_req_o   (pump_req),
        .rd_addr_o  (pump_addr),
        .rd_ack_i   (pump_ack),
        .rd_data_i  (mem_rdata_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_ready_i (tx_ready_i)
    );

    // Control decodes shared by the port mux and the sequencer.
    always_comb begin
        dscr_bad    = owner_bad || range_bad;
        pump_load   = (state_q == ST_CHK) && !dscr_bad;
        pump_ack    = mem_ack_i && (state_q == ST_XFER);
        running     = (state_q != ST_IDLE) && (state_q != ST_END) && (state_q != ST_STUCK);
        wb_done     = (state_q == ST_WB) && (loop_test_i || mem_ack_i);
        restart_any = rs_pend_q || restart_i;
    end

    // Memory port mux: descriptor reads, write-back, or pump reads.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_q;
        mem_wdata_o = ctrl_q & OWN_CLR;
        unique case (state_q)
            ST_W0:   mem_req_o = 1'b1;
            ST_W1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + OFS_BUF;
            end
            ST_W2, ST_LINK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + OFS_NEXT;
            end
            ST_XFER: begin
                mem_req_o  = pump_req;
                mem_addr_o = pump_addr;
            end
            ST_WB: begin
                mem_req_o = !loop_test_i;
                mem_we_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencer: fetch, validate, stream, write back, link, end, lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            buf_q     <= '0;
            next_q    <= '0;
            ctrl_q    <= '0;
            last_q    <= '0;
            rs_pend_q <= 1'b0;
            eoc_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            eoc_q <= 1'b0;
            err_q <= 1'b0;
            if (restart_i && running) begin
                rs_pend_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cur_q   <= first_addr_i;
                        state_q <= ST_W0;
                    end
                end
                ST_W0: begin
                    if (mem_ack_i) begin
                        ctrl_q  <= mem_rdata_i;
                        state_q <= ST_W1;
                    end
                end
                ST_W1: begin
                    if (mem_ack_i) begin
                        buf_q   <= mem_rdata_i;
                        state_q <= ST_W2;
                    end
                end
                ST_W2: begin
                    if (mem_ack_i) begin
                        next_q  <= mem_rdata_i;
                        state_q <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    if (dscr_bad) begin
                        err_q   <= 1'b1;
                        state_q <= ST_STUCK;
                    end else begin
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!pump_busy) begin
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (wb_done) begin
                        if (restart_any) begin
                            rs_pend_q <= 1'b0;
                            state_q   <= ST_LINK;
                        end else if (ctrl_q[EOC_BIT]) begin
                            eoc_q   <= 1'b1;
                            last_q  <= cur_q;
                            state_q <= ST_END;
                        end else begin
                            cur_q   <= next_q;
                            state_q <= ST_W0;
                        end
                    end
                end
                ST_LINK: begin
                    if (mem_ack_i) begin
                        cur_q   <= mem_rdata_i;
                        state_q <= ST_W0;
                    end
                end
                ST_END: begin
                    if (start_i) begin
                        cur_q   <= first_addr_i;
                        state_q <= ST_W0;
                    end else if (restart_i) begin
                        state_q <= ST_LINK;
                    end
                end
                default: state_q <= ST_STUCK;
            endcase
        end
    end

    // Registered interrupt and status outputs.
    always_comb begin
        eoc_irq_o        = eoc_q;
        dscr_err_irq_o   = err_q;
        last_dscr_addr_o = last_q;
    end
endmodule

// File: rtl/dscr_chain_tx_chk.sv
// Property checker for dscr_chain_tx, attached by bind. It observes the
// ports and the sequencer state only.
module dscr_chain_tx_chk
    import dscr_pkg::*;
#(
    parameter logic [31:0] WIN_LO = 32'h3FC8_0000,
    parameter logic [31:0] WIN_HI = 32'h3FCD_FFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic [31:0] mem_wdata_o,
    input logic [7:0]  tx_data_o,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic        loop_test_i,
    input logic        eoc_irq_o,
    input logic        dscr_err_irq_o,
    input logic [31:0] last_dscr_addr_o,
    input eng_state_e  state_q
);
    localparam logic [31:0] WIN_LO_W = {WIN_LO[31:2], 2'b00};

    a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    a_r2_bytes_only_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> state_q == ST_XFER);

    a_r5_stream_reads_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_we_o && state_q == ST_XFER |->
            mem_addr_o >= WIN_LO_W && mem_addr_o <= WIN_HI);

    a_r4_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dscr_err_irq_o |=> !dscr_err_irq_o);

    a_r6_err_locks: assert property (@(posedge clk) disable iff (!rst_n)
        dscr_err_irq_o |-> state_q == ST_STUCK);

    a_r6_stuck_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STUCK |-> !mem_req_o && !tx_valid_o && !eoc_irq_o);

    a_r6_stuck_stays: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STUCK |=> state_q == ST_STUCK);

    a_r7_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

    a_r7_loop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        loop_test_i |-> !(mem_req_o && mem_we_o));

    a_r8_eoc_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq_o |=> !eoc_irq_o);

    a_r8_last_moves_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_dscr_addr_o) |-> eoc_irq_o);
endmodule

bind dscr_chain_tx dscr_chain_tx_chk #(
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .mem_req_o        (mem_req_o),
    .mem_we_o         (mem_we_o),
    .mem_addr_o       (mem_addr_o),
    .mem_wdata_o      (mem_wdata_o),
    .tx_data_o        (tx_data_o),
    .tx_valid_o       (tx_valid_o),
    .tx_ready_i       (tx_ready_i),
    .loop_test_i      (loop_test_i),
    .eoc_irq_o        (eoc_irq_o),
    .dscr_err_irq_o   (dscr_err_irq_o),
    .last_dscr_addr_o (last_dscr_addr_o),
    .state_q          (state_q)
);

// File: tb/dscr_chain_tx_test.sv
// Bench for dscr_chain_tx. A 4 KiB memory model aliases across the address
// window. Buffer bytes follow an arithmetic pattern of their address, and
// the acknowledge and ready inputs stall in fixed rhythms.
module dscr_chain_tx_test;
    localparam logic [31:0] BASE = 32'h3FC8_0000;
    localparam logic [31:0] D0 = BASE + 32'hC00;
    localparam logic [31:0] D1 = BASE + 32'hC10;
    localparam logic [31:0] D2 = BASE + 32'hC20;
    localparam logic [31:0] D3 = BASE + 32'hC30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        restart_i = 1'b0;
    logic [31:0] first_addr_i = '0;
    logic        check_owner_i = 1'b0;
    logic        loop_test_i = 1'b0;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b0;
    logic        eoc_irq_o, dscr_err_irq_o;
    logic [31:0] last_dscr_addr_o;

    logic [31:0] mem [0:1023];
    logic [7:0]  cap [0:255];
    int cap_cnt = 0, eoc_cnt = 0, err_cnt = 0, wr_cnt = 0, req_cnt = 0;
    int checks = 0, errors = 0, cyc = 0;
    logic ack_en = 1'b0;

    always #10 clk = ~clk;

    dscr_chain_tx uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
        .first_addr_i(first_addr_i), .check_owner_i(check_owner_i),
        .loop_test_i(loop_test_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
        .tx_ready_i(tx_ready_i), .eoc_irq_o(eoc_irq_o),
        .dscr_err_irq_o(dscr_err_irq_o), .last_dscr_addr_o(last_dscr_addr_o)
    );

    assign mem_ack_i   = mem_req_o && ack_en;
    assign mem_rdata_i = mem[mem_addr_o[11:2]];

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'hA5;
    endfunction

    function automatic logic [31:0] ctrlw(input logic own, input logic eoc, input int len);
        return {own, eoc, 6'd0, 12'(len), 12'(len)};
    endfunction

    // Stall rhythms, driven away from the active edge.
    always @(negedge clk) begin
        ack_en     <= (cyc % 3) != 0;
        tx_ready_i <= (cyc % 5) != 1;
    end

    // Memory writes and output monitors.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_o && mem_ack_i) req_cnt <= req_cnt + 1;
        if (mem_req_o && mem_ack_i && mem_we_o) begin
            mem[mem_addr_o[11:2]] <= mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (tx_valid_o && tx_ready_i) begin
            cap[cap_cnt[7:0]] <= tx_data_o;
            cap_cnt <= cap_cnt + 1;
        end
        if (eoc_irq_o) eoc_cnt <= eoc_cnt + 1;
        if (dscr_err_irq_o) err_cnt <= err_cnt + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] a = BASE + 32'(4 * i);
            mem[i] = {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
        end
    endtask

    task automatic put_dscr(input logic [31:0] d, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        mem[d[11:2]]        = w0;
        mem[d[11:2] + 10'd1] = w1;
        mem[d[11:2] + 10'd2] = w2;
    endtask

    task automatic clr();
        @(negedge clk);
        cap_cnt = 0; eoc_cnt = 0; err_cnt = 0; wr_cnt = 0; req_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr();
    endtask

    task automatic pulse_start(input logic [31:0] a);
        @(negedge clk);
        start_i = 1'b1; first_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
    endtask

    task automatic wait_evt(input int lim);
        int e0 = eoc_cnt;
        int r0 = err_cnt;
        int n = 0;
        while (eoc_cnt == e0 && err_cnt == r0 && n < lim) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Compares cap[at .. at+len-1] with the pattern from address b.
    task automatic chk_stream(input string what, input logic [31:0] b, input int len, input int at);
        int bad = -1;
        for (int i = 0; i < len; i++)
            if (bad < 0 && cap[at + i] !== pat(b + 32'(i))) bad = i;
        if (bad < 0) chk(1'b1, what, 0, 0);
        else chk(1'b0, what, {24'd0, cap[at + bad]}, {24'd0, pat(b + 32'(bad))});
    endtask

    initial begin
        fill_mem();
        do_reset();
        // R12: reset state
        chk(!mem_req_o && !tx_valid_o, "R12 idle outputs", {mem_req_o, tx_valid_o}, 0);
        chk(!eoc_irq_o && !dscr_err_irq_o, "R12 irqs low", {eoc_irq_o, dscr_err_irq_o}, 0);
        chk(last_dscr_addr_o == 0, "R12 last addr", last_dscr_addr_o, 0);

        // R11: restart before any start does nothing
        pulse_restart();
        repeat (30) @(negedge clk);
        chk(req_cnt == 0 && cap_cnt == 0, "R11 restart in idle", req_cnt, 0);

        // R2 R7 R8: sweep over alignment and byte count, one descriptor
        for (int off = 0; off < 4; off++) begin
            for (int len = 1; len <= 12; len++) begin
                logic [31:0] b = BASE + 32'h100 + 32'(off);
                put_dscr(D0, ctrlw(1'b1, 1'b1, len), b, 32'd0);
                clr();
                pulse_start(D0);
                wait_evt(2000);
                chk(cap_cnt == len, "R2 byte count", cap_cnt, len);
                chk_stream("R2 byte order", b, len, 0);
                chk(eoc_cnt == 1, "R8 one end pulse", eoc_cnt, 1);
                chk(last_dscr_addr_o == D0, "R8 last addr", last_dscr_addr_o, D0);
                chk(mem[D0[11:2]] == (ctrlw(1'b1, 1'b1, len) & 32'h7FFF_FFFF),
                    "R7 write-back", mem[D0[11:2]], ctrlw(1'b1, 1'b1, len) & 32'h7FFF_FFFF);
            end
        end

        // R1 R11: three-descriptor chain; a second start mid-run is ignored
        fill_mem();
        put_dscr(D0, ctrlw(1'b1, 1'b0, 5), BASE + 32'h203, D1);
        put_dscr(D1, ctrlw(1'b1, 1'b0, 1), BASE + 32'h300, D2);
        put_dscr(D2, ctrlw(1'b1, 1'b1, 7), BASE + 32'h402, 32'd0);
        put_dscr(D3, ctrlw(1'b1, 1'b1, 9), BASE + 32'h500, 32'd0);
        clr();
        pulse_start(D0);
        repeat (6) @(negedge clk);
        pulse_start(D3);
        wait_evt(3000);
        chk(cap_cnt == 13, "R1 chain byte total", cap_cnt, 13);
        chk_stream("R1 chain part 0", BASE + 32'h203, 5, 0);
        chk_stream("R1 chain part 1", BASE + 32'h300, 1, 5);
        chk_stream("R11 chain part 2 after ignored start", BASE + 32'h402, 7, 6);
        chk(last_dscr_addr_o == D2 && eoc_cnt == 1, "R8 chain end", last_dscr_addr_o, D2);
        chk(!mem[D0[11:2]][31] && !mem[D1[11:2]][31] && !mem[D2[11:2]][31],
            "R7 chain owners cleared", mem[D1[11:2]], 0);

        // R7: loop test suppresses the write-back
        loop_test_i = 1'b1;
        put_dscr(D0, ctrlw(1'b1, 1'b1, 3), BASE + 32'h101, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        chk(wr_cnt == 0, "R7 loop test no write", wr_cnt, 0);
        chk(mem[D0[11:2]] == ctrlw(1'b1, 1'b1, 3), "R7 loop test word kept", mem[D0[11:2]], ctrlw(1'b1, 1'b1, 3));
        loop_test_i = 1'b0;

        // R4: owner flag 0 accepted while checking is off
        put_dscr(D0, ctrlw(1'b0, 1'b1, 4), BASE + 32'h120, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 0 && cap_cnt == 4, "R4 owner unchecked", cap_cnt, 4);

        // R5: window boundaries accepted
        put_dscr(D0, ctrlw(1'b1, 1'b1, 1), 32'h3FCD_FFFF, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 0 && cap_cnt == 1 && cap[0] == pat(32'h3FCD_FFFF), "R5 upper bound ok", {24'd0, cap[0]}, {24'd0, pat(32'h3FCD_FFFF)});
        put_dscr(D0, ctrlw(1'b1, 1'b1, 2), 32'h3FC8_0000, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 0 && cap_cnt == 2, "R5 lower bound ok", cap_cnt, 2);

        // R5 R6: outside the window, below then above
        put_dscr(D0, ctrlw(1'b1, 1'b1, 2), 32'h3FC7_FFFF, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 1 && cap_cnt == 0, "R5 below window", err_cnt, 1);
        do_reset();
        put_dscr(D0, ctrlw(1'b1, 1'b1, 2), 32'h3FCE_0000, 32'd0);
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 1 && cap_cnt == 0, "R5 above window", err_cnt, 1);

        // R4: owner fault with checking on
        do_reset();
        check_owner_i = 1'b1;
        put_dscr(D0, ctrlw(1'b0, 1'b1, 4), BASE + 32'h120, 32'd0);
        pulse_start(D0);
        wait_evt(2000);
        chk(err_cnt == 1 && cap_cnt == 0 && eoc_cnt == 0, "R4 owner fault", err_cnt, 1);

        // R6: locked engine ignores start and restart
        put_dscr(D0, ctrlw(1'b1, 1'b1, 4), BASE + 32'h120, 32'd0);
        clr();
        pulse_start(D0);
        pulse_restart();
        repeat (60) @(negedge clk);
        chk(req_cnt == 0 && cap_cnt == 0 && eoc_cnt == 0 && err_cnt == 0, "R6 stays locked", req_cnt, 0);
        do_reset();
        pulse_start(D0);
        wait_evt(2000);
        chk(eoc_cnt == 1 && cap_cnt == 4, "R6 recovers after reset", cap_cnt, 4);
        check_owner_i = 1'b0;

        // R9: restart after end follows the rewritten next pointer
        put_dscr(D0, ctrlw(1'b1, 1'b1, 3), BASE + 32'h140, 32'd0);
        put_dscr(D1, ctrlw(1'b1, 1'b1, 6), BASE + 32'h181, 32'd0);
        clr();
        pulse_start(D0);
        wait_evt(2000);
        clr();
        mem[D0[11:2] + 10'd2] = D1;
        pulse_restart();
        wait_evt(2000);
        chk(cap_cnt == 6 && eoc_cnt == 1, "R9 restart after end count", cap_cnt, 6);
        chk_stream("R9 restart after end bytes", BASE + 32'h181, 6, 0);
        chk(last_dscr_addr_o == D1, "R9 last addr", last_dscr_addr_o, D1);

        // R10: restart while running; the end flag of D0 is overridden
        put_dscr(D0, ctrlw(1'b1, 1'b1, 40), BASE + 32'h1C2, 32'd0);
        put_dscr(D1, ctrlw(1'b1, 1'b1, 5), BASE + 32'h243, 32'd0);
        clr();
        pulse_start(D0);
        while (cap_cnt < 2) @(negedge clk);
        mem[D0[11:2] + 10'd2] = D1;
        pulse_restart();
        wait_evt(4000);
        chk(cap_cnt == 45 && eoc_cnt == 1, "R10 running restart count", cap_cnt, 45);
        chk_stream("R10 first buffer", BASE + 32'h1C2, 40, 0);
        chk_stream("R10 appended buffer", BASE + 32'h243, 5, 40);
        chk(last_dscr_addr_o == D1, "R10 last addr", last_dscr_addr_o, D1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule